// File: doc/BRIEF.md
# I2C Audio Switch Control Receiver

This block is a write-only I2C target that holds the control state of a six-channel audio switch. A host writes one address byte and then any number of one-byte commands; each command changes the input source, a mute flag, the surround-enhance enable or the mixed-channel gain. SCL and SDA are oversampled by a system clock at least 20 times the bus bit rate. They pass through two-flop synchronizers, and START, STOP and SCL edges are found by comparing successive samples.

Command bytes come in several formats and are decoded independently. Codes that match none of the defined patterns are acknowledged but have no effect. After reset the block ignores the bus for a parameterized number of clock cycles. The bus needs this settling time after power-up.

Top module: `audio_sel_ctrl`

## Requirements
- R1: A START (SDA falls while SCL is high) begins address reception from any state, including a repeated START mid-transfer. A STOP (SDA rises while SCL is high) returns the block to idle.
- R2: The first byte after START is compared with 8'b1001_0100 (7-bit address 7'b1001010, write bit 0). On a match the block acknowledges. On any other byte, including the same address with the read bit set, it gives no acknowledge and ignores the bus until the next START.
- R3: Acknowledge timing: sda_pull_o goes high only while SCL is low, after the SCL fall that ends bit 8. It is released after the SCL fall that ends the ninth clock. Bits are taken MSB first on SCL rising edges.
- R4: Any number of data bytes may follow the address. Each one is acknowledged and applied as a separate command in the order received.
- R5: A byte 1100_cccc sets src_sel_o as follows: 1011 gives 0 (stereo group 1), 1010 gives 1 (group 2), 1001 gives 2 (group 3), 1000 gives 3 (group 4), and 0111 gives 4 (direct six-channel input). Any other cccc leaves it unchanged.
- R6: A byte 1111_kkk_m with kkk from 0 to 5 sets mute_o[kkk] to m. The bit order is 0 FL, 1 FR, 2 CT, 3 SUB, 4 SL, 5 SR. kkk = 110 has no effect.
- R7: A byte 1111_111_m sets all six mute_o bits to m.
- R8: 8'hD0 sets the stored enhance enable and 8'hD1 clears it. enh_o equals the stored enable only while src_sel_o is below 4, and is 0 while the direct input is selected.
- R9: 8'h90 clears gain6_o (0 dB) and 8'h91 sets it (+6 dB).
- R10: For LOCKOUT_CYCLES cycles after reset the block never drives SDA and applies no command.
- R11: Data bytes that match no pattern are acknowledged but leave all outputs unchanged.
- R12: Reset values: mute_o = 6'b111111, src_sel_o = 0, enh_o = 0, gain6_o = 0, sda_pull_o = 0.
- R13: A STOP, or a START, that arrives before the SCL fall ending bit 8 discards the partial byte without applying it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, at least 20x the bus bit rate |
| rst_ni | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | I2C clock line level |
| sda_i | input | 1 | I2C data line level |
| sda_pull_o | output | 1 | Open-drain enable: 1 pulls SDA low |
| src_sel_o | output | 3 | Source: 0-3 stereo groups 1-4, 4 direct six-channel |
| mute_o | output | 6 | Per-channel mute, 1 = muted (FL,FR,CT,SUB,SL,SR from bit 0) |
| enh_o | output | 1 | Effective surround enhance |
| gain6_o | output | 1 | Mixed-channel gain, 1 = +6 dB |

## Verification
The bench sends all 256 data byte values in a single transfer and checks the acknowledge and all outputs against an arithmetic model after each byte. A decoder that confuses mute channel codes, accepts undefined select codes or treats the address value as a command shows up as a mismatch on some byte. Wrong addresses, the read bit and traffic inside the lockout window must draw no acknowledge and no change; a block that leaked through would unmute channels. Partial bytes cut off by STOP or by a repeated START must not take effect, and enhance must be masked while the direct input is selected.

// File: rtl/audio_sel_pkg.sv
package audio_sel_pkg;
  localparam int unsigned NUM_CH = 6;

  typedef enum logic [2:0] {
    SRC_GRP1   = 3'd0,
    SRC_GRP2   = 3'd1,
    SRC_GRP3   = 3'd2,
    SRC_GRP4   = 3'd3,
    SRC_DIRECT = 3'd4
  } src_e;

  typedef enum logic [2:0] {
    RX_IDLE,
    RX_ADDR,
    RX_DATA,
    RX_ACK,
    RX_IGNORE
  } rx_state_e;

  localparam logic [3:0] HDR_SRC  = 4'b1100;
  localparam logic [3:0] HDR_MUTE = 4'b1111;
  localparam logic [2:0] MUTE_ALL = 3'b111;
  localparam logic [7:0] CMD_ENH_ON   = 8'hD0;
  localparam logic [7:0] CMD_ENH_OFF  = 8'hD1;
  localparam logic [7:0] CMD_GAIN_0DB = 8'h90;
  localparam logic [7:0] CMD_GAIN_6DB = 8'h91;
endpackage

// File: rtl/sync_stage.sv
module sync_stage #(
  parameter int unsigned STAGES = 2,
  parameter logic        INIT   = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= {STAGES{INIT}};
    else         chain_q <= {chain_q[STAGES-2:0], d_i};
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/i2c_line_mon.sv
module i2c_line_mon #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_o,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [1:0] raw;
  logic [1:0] syn;
  logic       scl_q, sda_q;

  assign raw = {scl_i, sda_i};

  for (genvar g = 0; g < 2; g++) begin : g_sync
    sync_stage #(.STAGES(SYNC_STAGES), .INIT(1'b1)) u_sync (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .d_i   (raw[g]),
      .q_o   (syn[g])
    );
  end

  assign scl_o = syn[1];
  assign sda_o = syn[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_o;
      sda_q <= sda_o;
    end
  end

  assign scl_rise_o = scl_o & ~scl_q;
  assign scl_fall_o = ~scl_o & scl_q;
  assign start_o    = scl_o & scl_q & sda_q & ~sda_o;
  assign stop_o     = scl_o & scl_q & ~sda_q & sda_o;

  AST_START_STOP_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(start_o && stop_o)); // R1
endmodule

// File: rtl/i2c_cmd_rx.sv
module i2c_cmd_rx
  import audio_sel_pkg::*;
#(
  parameter logic [6:0]  DEV_ADDR       = 7'b1001010,
  parameter int unsigned LOCKOUT_CYCLES = 75_000_000
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic       scl_rise_i,
  input  logic       scl_fall_i,
  input  logic       start_i,
  input  logic       stop_i,
  output logic       sda_pull_o,
  output logic       cmd_valid_o,
  output logic [7:0] cmd_byte_o
);
  localparam int unsigned LW = $clog2(LOCKOUT_CYCLES + 1);
  localparam logic [LW-1:0] LOCK_END = LW'(LOCKOUT_CYCLES);
  localparam logic [7:0] ADDR_WR = {DEV_ADDR, 1'b0};

  logic [LW-1:0] lock_cnt_q;
  logic          lock_active;
  rx_state_e     st_q;
  logic [3:0]    bit_cnt_q;
  logic [7:0]    shreg_q;
  logic          pull_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 lock_cnt_q <= '0;
    else if (lock_cnt_q != LOCK_END) lock_cnt_q <= lock_cnt_q + 1'b1;
  end

  assign lock_active = (lock_cnt_q != LOCK_END);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q        <= RX_IDLE;
      bit_cnt_q   <= '0;
      shreg_q     <= '0;
      pull_q      <= 1'b0;
      cmd_valid_o <= 1'b0;
      cmd_byte_o  <= '0;
    end else begin
      cmd_valid_o <= 1'b0;
      if (lock_active || stop_i) begin
        st_q   <= RX_IDLE;
        pull_q <= 1'b0;
      end else if (start_i) begin
        st_q      <= RX_ADDR;
        bit_cnt_q <= '0;
        pull_q    <= 1'b0;
      end else begin
        unique case (st_q)
          RX_ADDR, RX_DATA: begin
            if (scl_rise_i && bit_cnt_q != 4'd8) begin
              shreg_q   <= {shreg_q[6:0], sda_i};
              bit_cnt_q <= bit_cnt_q + 4'd1;
            end else if (scl_fall_i && bit_cnt_q == 4'd8) begin
              if (st_q == RX_ADDR) begin
                if (shreg_q == ADDR_WR) begin
                  st_q   <= RX_ACK;
                  pull_q <= 1'b1;
                end else begin
                  st_q <= RX_IGNORE;
                end
              end else begin
                st_q        <= RX_ACK;
                pull_q      <= 1'b1;
                cmd_valid_o <= 1'b1;
                cmd_byte_o  <= shreg_q;
              end
            end
          end
          RX_ACK: begin
            if (scl_fall_i) begin
              pull_q    <= 1'b0;
              st_q      <= RX_DATA;
              bit_cnt_q <= '0;
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign sda_pull_o = pull_q;

  AST_PULL_ON_LOW_SCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pull_q) |-> !scl_i); // R3
  AST_LOCK_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_active |-> (!pull_q && !cmd_valid_o)); // R10
  AST_ONE_CMD_PER_BYTE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o |=> !cmd_valid_o); // R4
  AST_STOP_NO_CMD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i |=> !cmd_valid_o); // R13
endmodule

// File: rtl/audio_cmd_decode.sv
module audio_cmd_decode
  import audio_sel_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_valid_i,
  input  logic [7:0]        cmd_byte_i,
  output logic [2:0]        src_sel_o,
  output logic [NUM_CH-1:0] mute_o,
  output logic              enh_o,
  output logic              gain6_o
);
  src_e              src_q;
  logic [NUM_CH-1:0] mute_q;
  logic              enh_q, gain_q;
  logic [3:0]        hdr, low;
  logic [2:0]        ch_sel;
  logic              is_mute;

  assign hdr     = cmd_byte_i[7:4];
  assign low     = cmd_byte_i[3:0];
  assign ch_sel  = cmd_byte_i[3:1];
  assign is_mute = cmd_valid_i && (hdr == HDR_MUTE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      src_q <= SRC_GRP1;
    end else if (cmd_valid_i && hdr == HDR_SRC) begin
      case (low)
        4'b1011: src_q <= SRC_GRP1;
        4'b1010: src_q <= SRC_GRP2;
        4'b1001: src_q <= SRC_GRP3;
        4'b1000: src_q <= SRC_GRP4;
        4'b0111: src_q <= SRC_DIRECT;
        default: ;
      endcase
    end
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_mute
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) mute_q[c] <= 1'b1;
      else if (is_mute && (ch_sel == 3'(c) || ch_sel == MUTE_ALL))
        mute_q[c] <= cmd_byte_i[0];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      enh_q  <= 1'b0;
      gain_q <= 1'b0;
    end else if (cmd_valid_i) begin
      case (cmd_byte_i)
        CMD_ENH_ON:   enh_q  <= 1'b1;
        CMD_ENH_OFF:  enh_q  <= 1'b0;
        CMD_GAIN_0DB: gain_q <= 1'b0;
        CMD_GAIN_6DB: gain_q <= 1'b1;
        default: ;
      endcase
    end
  end

  assign src_sel_o = src_q;
  assign mute_o    = mute_q;
  assign enh_o     = enh_q && (src_q != SRC_DIRECT);
  assign gain6_o   = gain_q;

  AST_IDLE_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cmd_valid_i |=> $stable({src_q, mute_q, enh_q, gain_q})); // R11
  AST_SRC_LEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    src_q <= SRC_DIRECT); // R5
  AST_MUTE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_mute && ch_sel != MUTE_ALL) |=> $countones(mute_q ^ $past(mute_q)) <= 1); // R6
endmodule

// File: rtl/audio_sel_ctrl.sv
module audio_sel_ctrl
  import audio_sel_pkg::*;
#(
  parameter logic [6:0]  DEV_ADDR       = 7'b1001010,
  parameter int unsigned LOCKOUT_CYCLES = 75_000_000,
  parameter int unsigned SYNC_STAGES    = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_pull_o,
  output logic [2:0] src_sel_o,
  output logic [5:0] mute_o,
  output logic       enh_o,
  output logic       gain6_o
);
  logic       scl_s, sda_s, scl_rise, scl_fall, start_p, stop_p;
  logic       cmd_valid;
  logic [7:0] cmd_byte;

  i2c_line_mon #(.SYNC_STAGES(SYNC_STAGES)) u_mon (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .scl_i     (scl_i),
    .sda_i     (sda_i),
    .scl_o     (scl_s),
    .sda_o     (sda_s),
    .scl_rise_o(scl_rise),
    .scl_fall_o(scl_fall),
    .start_o   (start_p),
    .stop_o    (stop_p)
  );

  i2c_cmd_rx #(.DEV_ADDR(DEV_ADDR), .LOCKOUT_CYCLES(LOCKOUT_CYCLES)) u_rx (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .scl_i      (scl_s),
    .sda_i      (sda_s),
    .scl_rise_i (scl_rise),
    .scl_fall_i (scl_fall),
    .start_i    (start_p),
    .stop_i     (stop_p),
    .sda_pull_o (sda_pull_o),
    .cmd_valid_o(cmd_valid),
    .cmd_byte_o (cmd_byte)
  );

  audio_cmd_decode u_dec (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cmd_valid_i(cmd_valid),
    .cmd_byte_i (cmd_byte),
    .src_sel_o  (src_sel_o),
    .mute_o     (mute_o),
    .enh_o      (enh_o),
    .gain6_o    (gain6_o)
  );
endmodule

// File: tb/audio_sel_ctrl_tb_top.sv
`timescale 1ns/1ps
module audio_sel_ctrl_tb_top;
  localparam int LOCK = 800;
  localparam int H    = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic sda_pull;
  logic sda_bus;
  logic [2:0] src_sel;
  logic [5:0] mute;
  logic enh, gain6;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  logic [2:0] e_src;
  logic [5:0] e_mute;
  logic       e_enh_st, e_gain;

  always #2 clk = ~clk;
  assign sda_bus = sda_m & ~sda_pull;

  audio_sel_ctrl #(.LOCKOUT_CYCLES(LOCK)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl_m), .sda_i(sda_bus),
    .sda_pull_o(sda_pull), .src_sel_o(src_sel), .mute_o(mute),
    .enh_o(enh), .gain6_o(gain6)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wt(H); scl_m = 1'b1; wt(H);
    sda_m = 1'b0; wt(H); scl_m = 1'b0; wt(H);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wt(H); scl_m = 1'b1; wt(H);
    sda_m = 1'b1; wt(H);
  endtask

  task automatic send_bit(input logic b);
    sda_m = b; wt(H); scl_m = 1'b1; wt(H); scl_m = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] b, output logic acked);
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
    sda_m = 1'b1; wt(H); scl_m = 1'b1; wt(H/2);
    acked = ~sda_bus;
    wt(H/2); scl_m = 1'b0;
  endtask

  // expected-state model built from R5..R9, R11
  task automatic model(input logic [7:0] b);
    if (b[7:4] == 4'b1100) begin
      case (b[3:0])
        4'b1011: e_src = 3'd0;
        4'b1010: e_src = 3'd1;
        4'b1001: e_src = 3'd2;
        4'b1000: e_src = 3'd3;
        4'b0111: e_src = 3'd4;
        default: ;
      endcase
    end else if (b[7:4] == 4'b1111) begin
      if (b[3:1] == 3'b111) e_mute = {6{b[0]}};
      else if (b[3:1] < 3'd6) e_mute[b[3:1]] = b[0];
    end else if (b == 8'hD0) e_enh_st = 1'b1;
    else if (b == 8'hD1) e_enh_st = 1'b0;
    else if (b == 8'h90) e_gain = 1'b0;
    else if (b == 8'h91) e_gain = 1'b1;
  endtask

  task automatic chk_state(input string req);
    chk({req, " src"},  src_sel, e_src);
    chk({req, " mute"}, mute, e_mute);
    chk({req, " enh"},  enh, (e_enh_st && e_src != 3'd4));
    chk({req, " gain"}, gain6, e_gain);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic ack;
    e_src = 3'd0; e_mute = 6'h3F; e_enh_st = 1'b0; e_gain = 1'b0;
    wt(5); rst_n = 1'b1; wt(2);

    // R12 reset values
    chk_state("R12");
    chk("R12 pull", sda_pull, 0);

    // R10 traffic inside lockout window: no ack, no effect
    bus_start();
    send_byte(8'h94, ack); chk("R10 addr ack", ack, 0);
    send_byte(8'hFE, ack); chk("R10 data ack", ack, 0);
    bus_stop();
    chk_state("R10");
    wt(LOCK);

    // R2 wrong address and read bit: no ack, following byte ignored
    bus_start();
    send_byte(8'h96, ack); chk("R2 wrong addr ack", ack, 0);
    send_byte(8'hFE, ack); chk("R2 ignored data ack", ack, 0);
    bus_stop();
    chk_state("R2");
    bus_start();
    send_byte(8'h95, ack); chk("R2 read bit ack", ack, 0);
    bus_stop();
    chk_state("R2 read");

    // R4 R3 R5..R9 R11 all 256 data values in one transfer
    bus_start();
    send_byte(8'h94, ack); chk("R3 addr ack", ack, 1);
    for (int v = 0; v < 256; v++) begin
      send_byte(8'(v), ack);
      chk("R4 R11 data ack", ack, 1);
      model(8'(v));
      chk_state("R4 sweep");
    end
    bus_stop();
    wt(4);
    chk("R3 pull released", sda_pull, 0);

    // R8 enhance gated by direct input
    bus_start();
    send_byte(8'h94, ack);
    send_byte(8'hC7, ack); model(8'hC7);
    send_byte(8'hD0, ack); model(8'hD0);
    chk("R8 enh masked", enh, 0);
    send_byte(8'hC9, ack); model(8'hC9);
    chk("R8 enh active", enh, 1);
    send_byte(8'hFE, ack); model(8'hFE);   // R7 all unmute
    chk("R7 all unmute", mute, 6'h00);
    send_byte(8'hF7, ack); model(8'hF7);   // R6 SUB mute
    chk("R6 sub mute", mute, 6'b001000);
    send_byte(8'hFD, ack); model(8'hFD);   // R6 code 110 ignored
    chk("R6 code110", mute, 6'b001000);
    bus_stop();
    chk_state("R8");

    // R13 STOP mid-byte discards partial byte
    bus_start();
    send_byte(8'h94, ack);
    for (int i = 7; i >= 4; i--) send_bit(8'hFF >> i);
    bus_stop();
    chk_state("R13 stop");

    // R13 R1 repeated START mid-byte then new command applies
    bus_start();
    send_byte(8'h94, ack);
    for (int i = 7; i >= 1; i--) send_bit(1'b1);
    bus_start();
    chk_state("R13 rstart");
    send_byte(8'h94, ack); chk("R1 rstart addr ack", ack, 1);
    send_byte(8'hF1, ack); model(8'hF1);
    bus_stop();
    chk_state("R1");

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule